// File: doc/BRIEF.md
# Control Endpoint Receive Sequencer

This block runs the data-receive stage of a control endpoint without software help. Once armed by a start pulse, it waits for the endpoint to flag that a received packet is waiting. It then takes the packet's byte count and its last-packet marker, and moves exactly that many bytes from the endpoint receive FIFO onto a byte-wide valid/ready stream.

When a packet has been moved, the sequencer sends a one-cycle serviced pulse back to the endpoint controller. On the packet marked as the last one of the stage, a data-end pulse comes in the same cycle, and the sequencer falls back to idle until the next start. The FIFO is read in show-ahead fashion: the byte on `fifo_data` is the one consumed when `fifo_rd` is high at a rising edge. A read strobe is only raised when the downstream consumer accepts the byte, so back-pressure never loses or duplicates data.

Top module: `ctrl_rx_seq`

## Requirements
- R1: From idle, the sequencer stays idle while `start` is low. In idle, a high `pkt_rdy` causes no FIFO read, no `out_valid` and no pulse.
- R2: In receive mode with `pkt_rdy` low, the sequencer stays waiting. It raises no FIFO read, no `out_valid` and no pulse.
- R3: If `pkt_rdy` is high at the edge ending a waiting cycle, the next cycle samples `byte_cnt` and `last_pkt`. `out_valid` rises in the cycle after that. Exactly the sampled count n of bytes is then read. Each `out_data` equals the `fifo_data` byte consumed in that cycle.
- R4: The count is taken once, in the sample cycle. Changing `byte_cnt` while bytes are being moved does not change how many bytes are read.
- R5: A sampled count of zero issues no FIFO read. The serviced pulse comes in the cycle right after the sample cycle.
- R6: While `out_valid` is high and `out_ready` is low, `fifo_rd` stays low and `out_valid` stays high.
- R7: After a packet whose `last_pkt` sample was 0, `serviced` is high for exactly one cycle and `data_end` stays low. The sequencer remains in receive mode, so a later packet is taken without a new start.
- R8: After a packet whose `last_pkt` sample was 1, `serviced` and `data_end` are both high in the same single cycle. The sequencer then returns to idle, where `pkt_rdy` is again ignored as in R1.
- R9: `pkt_rdy` is not looked at in the pulse cycle. With `pkt_rdy` held high, the next packet's first `out_valid` comes three cycles after the serviced pulse.
- R10: A high `rst` at a rising edge puts the sequencer in idle. From the next cycle, all outputs are low and no read happens until a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Arms receive mode from idle |
| pkt_rdy | input | 1 | Endpoint reports a received packet waiting |
| byte_cnt | input | CNT_W | Byte count of the waiting packet |
| last_pkt | input | 1 | Waiting packet is the final one of the stage |
| fifo_rd | output | 1 | Consume the byte on fifo_data at this edge |
| fifo_data | input | DATA_W | Show-ahead head byte of the receive FIFO |
| out_valid | output | 1 | A byte is offered on out_data |
| out_ready | input | 1 | Consumer accepts the offered byte |
| out_data | output | DATA_W | Byte stream to the consumer |
| serviced | output | 1 | One-cycle acknowledge for each packet |
| data_end | output | 1 | One-cycle end-of-stage mark, with serviced |

## Verification
The embedded properties rely on a few input conditions. `pkt_rdy` must fall once a packet is serviced, unless another packet is truly waiting. `byte_cnt` and `last_pkt` must be valid in the cycle after `pkt_rdy` is seen. The FIFO must hold at least the advertised number of bytes. The bench models the FIFO as an endless computed byte pattern, so it never runs dry. It drives all inputs just after a rising edge and drops `pkt_rdy` in the cycle after each serviced pulse, except in the back-to-back case, where holding it high is the point of the test.

// File: rtl/ctrl_rx_pkg.sv
package ctrl_rx_pkg;

  typedef enum logic [2:0] {
    CRX_IDLE  = 3'd0,
    CRX_WAIT  = 3'd1,
    CRX_COUNT = 3'd2,
    CRX_DRAIN = 3'd3,
    CRX_ACK   = 3'd4
  } crx_state_e;

  typedef struct packed {
    logic serviced;
    logic data_end;
  } crx_ack_t;

endpackage

// File: rtl/crx_beat_ctr.sv
module crx_beat_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             fire,
  output logic             load_empty,
  output logic             final_beat
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // Remaining-byte arithmetic kept in functions so a reader can restate it.
  function automatic logic [CNT_W-1:0] next_rem(input logic [CNT_W-1:0] rem,
                                                input logic fire_i);
    return fire_i ? rem - ONE : rem;
  endfunction

  function automatic logic is_final(input logic [CNT_W-1:0] rem,
                                    input logic fire_i);
    return fire_i && (rem == ONE);
  endfunction

  function automatic logic is_empty(input logic [CNT_W-1:0] cnt);
    return cnt == '0;
  endfunction

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] beats_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      total_q <= '0;
      beats_q <= '0;
    end else if (load) begin
      rem_q   <= load_val;
      total_q <= load_val;
      beats_q <= '0;
    end else begin
      rem_q <= next_rem(rem_q, fire);
      if (fire) beats_q <= beats_q + ONE;
    end
  end

  assign load_empty = is_empty(load_val);
  assign final_beat = is_final(rem_q, fire);

  // R3: a byte is never taken once the latched count is used up
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    fire |-> (rem_q != '0));

  // R4: bytes taken plus bytes left always equals the count latched at the start
  a_r4_count_kept: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, beats_q} + {1'b0, rem_q}) == {1'b0, total_q});

endmodule

// File: rtl/crx_fsm.sv
module crx_fsm
  import ctrl_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic pkt_rdy,
  input  logic last_in,
  input  logic load_empty,
  input  logic final_beat,
  output logic load,
  output logic drain,
  output logic ack,
  output logic last_q
);

  crx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CRX_IDLE:  if (start)      state_d = CRX_WAIT;
      CRX_WAIT:  if (pkt_rdy)    state_d = CRX_COUNT;
      CRX_COUNT: state_d = load_empty ? CRX_ACK : CRX_DRAIN;
      CRX_DRAIN: if (final_beat) state_d = CRX_ACK;
      CRX_ACK:   state_d = last_q ? CRX_IDLE : CRX_WAIT;
      default:   state_d = CRX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CRX_IDLE;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == CRX_COUNT) last_q <= last_in;
    end
  end

  assign load  = (state_q == CRX_COUNT);
  assign drain = (state_q == CRX_DRAIN);
  assign ack   = (state_q == CRX_ACK);

  // R1: idle is left only through start
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == CRX_IDLE) && !start |=> (state_q == CRX_IDLE));

  // R2: waiting is held while no packet is flagged
  a_r2_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == CRX_WAIT) && !pkt_rdy |=> (state_q == CRX_WAIT));

  // R5: an empty count goes straight to the acknowledge cycle
  a_r5_zero_skips: assert property (@(posedge clk) disable iff (rst)
    (state_q == CRX_COUNT) && load_empty |=> ack);

  // R7: acknowledge lasts one cycle
  a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R8: the final acknowledge returns to idle
  a_r8_end_to_idle: assert property (@(posedge clk) disable iff (rst)
    ack && last_q |=> (state_q == CRX_IDLE));

  // R9: the flag is looked at again only from the waiting state after the pulse
  a_r9_ack_to_wait: assert property (@(posedge clk) disable iff (rst)
    ack && !last_q |=> (state_q == CRX_WAIT));

endmodule

// File: rtl/crx_out_stage.sv
module crx_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              drain,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              fifo_rd,
  output logic              fire
);

  // Show-ahead FIFO: head byte passes straight through, read only on accept.
  assign out_valid = drain;
  assign out_data  = fifo_data;
  assign fire      = drain && out_ready;
  assign fifo_rd   = fire;

endmodule

// File: rtl/ctrl_rx_seq.sv
module ctrl_rx_seq
  import ctrl_rx_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pkt_rdy,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              last_pkt,
  output logic              fifo_rd,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              serviced,
  output logic              data_end
);

  // Named internal events
  logic     ev_load;
  logic     ev_drain;
  logic     ev_ack;
  logic     ev_last;
  logic     ev_fire;
  logic     ev_load_empty;
  logic     ev_final_beat;
  crx_ack_t ack_w;

  crx_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pkt_rdy    (pkt_rdy),
    .last_in    (last_pkt),
    .load_empty (ev_load_empty),
    .final_beat (ev_final_beat),
    .load       (ev_load),
    .drain      (ev_drain),
    .ack        (ev_ack),
    .last_q     (ev_last)
  );

  crx_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load       (ev_load),
    .load_val   (byte_cnt),
    .fire       (ev_fire),
    .load_empty (ev_load_empty),
    .final_beat (ev_final_beat)
  );

  crx_out_stage #(.DATA_W(DATA_W)) u_out (
    .drain     (ev_drain),
    .out_ready (out_ready),
    .fifo_data (fifo_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .fifo_rd   (fifo_rd),
    .fire      (ev_fire)
  );

  assign ack_w.serviced = ev_ack;
  assign ack_w.data_end = ev_ack && ev_last;
  assign serviced       = ack_w.serviced;
  assign data_end       = ack_w.data_end;

  // R6: an offered byte stays offered until taken
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid);

  // R3: no byte is offered in the acknowledge cycle
  a_r3_quiet_ack: assert property (@(posedge clk) disable iff (rst)
    serviced |-> !out_valid && !fifo_rd);

  // R10: the cycle after a reset edge is quiet
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !serviced && !data_end);

endmodule

// File: tb/ctrl_rx_seq_bench.sv
`timescale 1ns/1ps
module ctrl_rx_seq_bench;

  localparam int CNT_W  = 7;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              pkt_rdy = 1'b0;
  logic [CNT_W-1:0]  byte_cnt = '0;
  logic              last_pkt = 1'b0;
  logic              fifo_rd;
  logic [DATA_W-1:0] fifo_data;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [DATA_W-1:0] out_data;
  logic              serviced;
  logic              data_end;

  always #10 clk = ~clk;

  ctrl_rx_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl_rx_seq (
    .clk(clk), .rst(rst), .start(start), .pkt_rdy(pkt_rdy),
    .byte_cnt(byte_cnt), .last_pkt(last_pkt), .fifo_rd(fifo_rd),
    .fifo_data(fifo_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .serviced(serviced), .data_end(data_end)
  );

  function automatic logic [7:0] pat(input logic [7:0] idx);
    return (idx * 8'd7) + 8'd3;
  endfunction

  // FIFO model and cycle counter
  logic [7:0] rd_ptr = 8'd0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_rd) rd_ptr <= rd_ptr + 8'd1;
  end
  assign fifo_data = pat(rd_ptr);

  int checks = 0, failures = 0;
  int rd_total = 0, data_err = 0, stall_err = 0;
  int svc_total = 0, de_total = 0, de_alone = 0, double_err = 0;
  int svc_cyc = -1, first_valid_cyc = -1;
  logic prev_svc = 1'b0;

  // Monitor, sampling mid-cycle
  always @(negedge clk) begin
    if (fifo_rd) begin
      rd_total++;
      if (out_data !== pat(rd_ptr)) data_err++;
      if (!out_ready || !out_valid) stall_err++;
    end
    if (out_valid && !out_ready && fifo_rd) stall_err++;
    if (out_valid && first_valid_cyc < 0) first_valid_cyc = cyc;
    if (serviced) begin
      svc_total++;
      svc_cyc = cyc;
      if (data_end) de_total++;
      if (prev_svc) double_err++;
    end
    if (data_end && !serviced) de_alone++;
    prev_svc = serviced;
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic pulse_start();
    tick(); start = 1'b1;
    tick(); start = 1'b0;
  endtask

  // R10: reset state
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    settle();
    chk(!out_valid && !fifo_rd && !serviced && !data_end, "R10",
        "outputs under reset", int'(out_valid) + int'(serviced), 0);
    tick(); rst = 1'b0;
  endtask

  // R1: idle ignores the packet flag
  task automatic t_idle_ignore(input string tag);
    int r0, s0;
    r0 = rd_total; s0 = svc_total;
    tick(); pkt_rdy = 1'b1; byte_cnt = 7'd4;
    repeat (10) tick();
    settle();
    chk(rd_total == r0, tag, "reads while idle", rd_total - r0, 0);
    chk(svc_total == s0 && !out_valid, tag, "pulses while idle", svc_total - s0, 0);
    tick(); pkt_rdy = 1'b0;
  endtask

  // R2: waiting without the flag
  task automatic t_wait_quiet();
    int r0, s0;
    r0 = rd_total; s0 = svc_total;
    repeat (10) tick();
    settle();
    chk(rd_total == r0 && !out_valid, "R2", "reads while waiting", rd_total - r0, 0);
    chk(svc_total == s0, "R2", "pulses while waiting", svc_total - s0, 0);
  endtask

  // One packet: mode 0 ready, 1 stalled pattern, 2 count changed mid-drain
  task automatic t_pkt(input int n, input logic last, input int mode,
                       input logic hold, input string tag);
    int r0, s0, d0, e0, st0, raise, k;
    r0 = rd_total; s0 = svc_total; d0 = de_total; e0 = data_err; st0 = stall_err;
    tick();
    byte_cnt = n[CNT_W-1:0]; last_pkt = last; out_ready = 1'b1;
    first_valid_cyc = -1; pkt_rdy = 1'b1; raise = cyc;
    settle();
    k = 0;
    while (svc_total == s0 && k < 1000) begin
      tick(); k++;
      if (mode == 1) out_ready = ((k % 3) != 1);
      if (mode == 2 && k == 4) byte_cnt = 7'(n + 5);
      settle();
    end
    first_valid_cyc = -1;
    tick();
    if (!hold) pkt_rdy = 1'b0;
    out_ready = 1'b1;
    settle(); settle();
    chk(rd_total - r0 == n, tag, "bytes read", rd_total - r0, n);
    chk(data_err == e0, tag, "byte order", data_err - e0, 0);
    chk(svc_total - s0 == 1 && double_err == 0, tag, "serviced pulses",
        svc_total - s0, 1);
    chk(de_total - d0 == int'(last) && de_alone == 0, tag, "data end pulses",
        de_total - d0, int'(last));
    if (mode == 0)
      chk(svc_cyc == raise + 2 + n, tag, "serviced timing", svc_cyc - raise, 2 + n);
    if (mode == 1)
      chk(stall_err == st0, tag, "read while stalled", stall_err - st0, 0);
  endtask

  // R3: first byte two cycles after the flag edge
  task automatic t_first_byte_timing();
    int raise;
    tick(); byte_cnt = 7'd3; last_pkt = 1'b0; first_valid_cyc = -1;
    pkt_rdy = 1'b1; raise = cyc;
    repeat (3) settle();
    chk(first_valid_cyc == raise + 2, "R3", "first valid cycle",
        first_valid_cyc - raise, 2);
    while (!serviced) settle();
    tick(); pkt_rdy = 1'b0;
    settle();
  endtask

  // R9: back-to-back packets with the flag held high
  task automatic t_back_to_back();
    int s1, k, s0;
    t_pkt(3, 1'b0, 0, 1'b1, "R9");
    s1 = svc_cyc;
    k = 0;
    while (first_valid_cyc < 0 && k < 20) begin settle(); k++; end
    chk(first_valid_cyc == s1 + 3, "R9", "next packet start",
        first_valid_cyc - s1, 3);
    s0 = svc_total;
    k = 0;
    while (svc_total == s0 && k < 50) begin settle(); k++; end
    tick(); pkt_rdy = 1'b0;
    settle();
  endtask

  // R8: after the last packet, idle ignores the flag again
  task automatic t_after_last();
    int r0, s0;
    r0 = rd_total; s0 = svc_total;
    tick(); pkt_rdy = 1'b1; byte_cnt = 7'd5; last_pkt = 1'b0;
    repeat (8) tick();
    settle();
    chk(rd_total == r0 && svc_total == s0 && !out_valid, "R8",
        "idle after data end", rd_total - r0, 0);
    tick(); pkt_rdy = 1'b0;
  endtask

  // R10: reset while bytes are moving
  task automatic t_reset_mid();
    int r0, s0;
    pulse_start();
    tick(); byte_cnt = 7'd20; last_pkt = 1'b0; out_ready = 1'b1; pkt_rdy = 1'b1;
    repeat (6) tick();
    rst = 1'b1;
    tick(); rst = 1'b0;
    settle();
    r0 = rd_total; s0 = svc_total;
    chk(!out_valid && !fifo_rd, "R10", "quiet after reset", int'(out_valid), 0);
    repeat (10) tick();
    settle();
    chk(rd_total == r0 && svc_total == s0, "R10", "idle after reset",
        rd_total - r0, 0);
    tick(); pkt_rdy = 1'b0;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_ignore("R1");
    pulse_start();
    t_wait_quiet();
    t_first_byte_timing();
    t_pkt(5, 1'b0, 0, 1'b0, "R7");
    t_pkt(0, 1'b0, 0, 1'b0, "R5");
    t_pkt(12, 1'b0, 1, 1'b0, "R6");
    t_pkt(10, 1'b0, 2, 1'b0, "R4");
    t_back_to_back();
    t_pkt(6, 1'b1, 0, 1'b0, "R8");
    t_after_last();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule